// File: doc/BRIEF.md
# Variable-Width PWM Timer

This block is a general-purpose 16-bit timer that can also generate a pulse-width modulated waveform on a single output. A two-bit mode field picks one of four arrangements: two independent 8-bit interval timers, an 8-bit interval timer next to an 8-bit PWM, a single 16-bit interval timer, or one PWM whose counter width can be set anywhere from 9 to 16 bits. Each half of the timer raises its own one-clock request pulse. The two requests are also merged onto a single shared interrupt line.

Time is measured with a tick enable, `tick_x2_i`, that pulses at twice the machine-cycle rate. Every second tick is one machine cycle, and the two 8-bit modes always advance at that rate. The two wide modes can be switched to advance on every tick, which gives half-cycle resolution. Software writes period, duty and control values through a simple write port. Period and duty values are staged first and copied into the working set at the next period boundary, so a waveform is never cut short. While the timer is stopped, staged values are copied straight through.

Top module: `pwm_timer16`

## Requirements
- R1: While `rst_ni` is low, `pwm_o`, `irq_lo_o`, `irq_hi_o` and `irq_o` are all low. All staged, working, control and counter state resets to zero.
- R2: In mode 0 (control bits [1:0] = 0), the low and high halves are independent 8-bit timers. Each counts 0 up to its period (address 0 = low period, address 1 = high period), returns to 0 on the next step, and pulses its own request (`irq_lo_o` or `irq_hi_o`) for one clock. `pwm_o` stays low.
- R3: A machine-cycle step happens on every second `tick_x2_i` pulse while running, counted from the cycle run was set. The two 8-bit modes advance only on machine-cycle steps, and a request pulse is only ever produced in the clock after a tick.
- R4: In mode 1, the low half is the 8-bit timer of R2. The high half free-runs through 256 machine-cycle steps. `pwm_o` is high while that count is below the high duty byte (address 3), and `irq_hi_o` pulses when the count wraps from 255.
- R5: In mode 2, both halves form one 16-bit counter that runs from 0 up to the 16-bit period {address 1, address 0} and then wraps. `irq_hi_o` pulses at each wrap, and `irq_lo_o` stays low.
- R6: In mode 3, the counter width is W = 9 + control bits [5:3]. The counter runs through 2^W steps. `pwm_o` is high while the count is below the 16-bit duty {address 3, address 2}, and `irq_hi_o` pulses at each wrap.
- R7: In modes 2 and 3, when control bit 2 is set, the counter steps on every `tick_x2_i` pulse instead of every second one.
- R8: A duty of zero keeps `pwm_o` constantly low. A duty at or above the period length (256 in mode 1, 2^W in mode 3) keeps it constantly high.
- R9: A period or duty written while running takes effect only at the next boundary of the half that uses it (a wide wrap updates both halves). While stopped, written values take effect one clock after the write.
- R10: `irq_o` is high exactly when `irq_lo_o` or `irq_hi_o` is high.
- R11: While the run bit (control bit 7, address 4) is clear, the counters are held at zero, `pwm_o` is low and no request pulses are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_x2_i | input | 1 | Time-base enable at twice the machine-cycle rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0/1 period low/high, 2/3 duty low/high, 4 control |
| wr_data_i | input | HALF_W | Write data |
| pwm_o | output | 1 | PWM waveform |
| irq_lo_o | output | 1 | Low-half request pulse |
| irq_hi_o | output | 1 | High-half request pulse |
| irq_o | output | 1 | Shared request line |

## Verification
A cycle-level reference model in the bench follows every mode. It is driven with both an always-on tick and a randomly gated tick. A steady tick checks the period arithmetic. A gated tick separates a step counted on every tick from one counted on every second tick. Duty values are set to zero, to mid-range and to values past the period length, which separates a less-than compare from a less-or-equal compare and confirms that the output saturates. Mid-period writes, with distinct widths from 9 to 16 bits, show whether values are applied at the boundary or at once. A run of randomly configured segments mixes all four modes.

// File: rtl/t1_pkg.sv
`timescale 1ns/1ps
package t1_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_TMR_PWM  = 2'd1,
    MODE_WIDE_TMR = 2'd2,
    MODE_WIDE_PWM = 2'd3
  } t1_mode_e;

  typedef struct packed {
    logic       run;
    logic       rsvd;
    logic [2:0] wsel;
    logic       half;
    t1_mode_e   mode;
  } t1_ctrl_t;

  localparam int unsigned ADDR_W       = 3;
  localparam int unsigned NUM_STAGED   = 4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
endpackage

// File: rtl/t1_step_gen.sv
`timescale 1ns/1ps
module t1_step_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic half_i,
  input  logic tick_i,
  output logic narrow_step_o,
  output logic wide_step_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (!run_i) phase_q <= 1'b0;
    else if (tick_i) phase_q <= ~phase_q;
  end

  assign narrow_step_o = run_i & tick_i & phase_q;
  assign wide_step_o   = half_i ? (run_i & tick_i) : narrow_step_o;
endmodule

// File: rtl/t1_regfile.sv
`timescale 1ns/1ps
module t1_regfile
  import t1_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              lo_load_i,
  input  logic              hi_load_i,
  output t1_ctrl_t          ctrl_o,
  output logic [HALF_W-1:0] per_lo_o,
  output logic [HALF_W-1:0] per_hi_o,
  output logic [HALF_W-1:0] duty_lo_o,
  output logic [HALF_W-1:0] duty_hi_o
);
  t1_ctrl_t          ctrl_q;
  logic [HALF_W-1:0] act_w [NUM_STAGED];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_CTRL) ctrl_q <= t1_ctrl_t'(wr_data_i[7:0]);
  end

  // even index feeds the low half, odd index the high half
  for (genvar g = 0; g < NUM_STAGED; g++) begin : g_slot
    logic [HALF_W-1:0] stg_q, act_q;
    logic              load;
    assign load = (g % 2 == 1) ? hi_load_i : lo_load_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == ADDR_W'(g)) stg_q <= wr_data_i;
        if (load)                                act_q <= stg_q;
      end
    end
    assign act_w[g] = act_q;
  end

  assign ctrl_o    = ctrl_q;
  assign per_lo_o  = act_w[0];
  assign per_hi_o  = act_w[1];
  assign duty_lo_o = act_w[2];
  assign duty_hi_o = act_w[3];
endmodule

// File: rtl/t1_core.sv
`timescale 1ns/1ps
module t1_core
  import t1_pkg::*;
#(
  parameter int unsigned HALF_W    = 8,
  parameter int unsigned MIN_PWM_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  t1_ctrl_t          ctrl_i,
  input  logic              narrow_step_i,
  input  logic              wide_step_i,
  input  logic [HALF_W-1:0] per_lo_i,
  input  logic [HALF_W-1:0] per_hi_i,
  input  logic [HALF_W-1:0] duty_lo_i,
  input  logic [HALF_W-1:0] duty_hi_i,
  output logic              lo_load_o,
  output logic              hi_load_o,
  output logic [HALF_W-1:0] cnt_lo_o,
  output logic [HALF_W-1:0] cnt_hi_o,
  output logic              pwm_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;
  localparam int unsigned SH_W  = $clog2(CNT_W + 1);

  logic [HALF_W-1:0] cnt_lo_q, cnt_hi_q, lo_nxt, hi_nxt, hi_lim;
  logic [CNT_W-1:0]  cnt16, cnt16_inc, wide_lim, pwm_lim, duty16;
  logic [CNT_W:0]    pow_w;
  logic [SH_W-1:0]   pwm_w_raw, pwm_w;
  logic              run, wide, lo_hit, hi_hit, wide_hit, irq_lo_q, irq_hi_q;

  assign run       = ctrl_i.run;
  assign wide      = ctrl_i.mode[1];
  assign cnt16     = {cnt_hi_q, cnt_lo_q};
  assign cnt16_inc = cnt16 + 1'b1;
  assign duty16    = {duty_hi_i, duty_lo_i};

  // programmable PWM width, clamped to the datapath
  always_comb begin
    pwm_w_raw = SH_W'(MIN_PWM_W) + SH_W'(ctrl_i.wsel);
    pwm_w     = (pwm_w_raw > SH_W'(CNT_W)) ? SH_W'(CNT_W) : pwm_w_raw;
    pow_w     = (CNT_W + 1)'(1) << pwm_w;
    pwm_lim   = pow_w[CNT_W-1:0] - 1'b1;
  end

  always_comb begin
    wide_lim = (ctrl_i.mode == MODE_WIDE_PWM) ? pwm_lim : {per_hi_i, per_lo_i};
    hi_lim   = (ctrl_i.mode == MODE_TMR_PWM) ? '1 : per_hi_i;
    lo_hit   = !wide && narrow_step_i && (cnt_lo_q == per_lo_i);
    hi_hit   = !wide && narrow_step_i && (cnt_hi_q == hi_lim);
    wide_hit = wide && wide_step_i && (cnt16 == wide_lim);

    lo_nxt = cnt_lo_q;
    hi_nxt = cnt_hi_q;
    if (!run) begin
      lo_nxt = '0;
      hi_nxt = '0;
    end else if (wide) begin
      if (wide_step_i) {hi_nxt, lo_nxt} = wide_hit ? '0 : cnt16_inc;
    end else if (narrow_step_i) begin
      lo_nxt = lo_hit ? '0 : cnt_lo_q + 1'b1;
      hi_nxt = hi_hit ? '0 : cnt_hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      cnt_lo_q <= lo_nxt;
      cnt_hi_q <= hi_nxt;
      irq_lo_q <= lo_hit;
      irq_hi_q <= hi_hit | wide_hit;
    end
  end

  always_comb begin
    unique case (ctrl_i.mode)
      MODE_TMR_PWM:  pwm_o = run && (cnt_hi_q < duty_hi_i);
      MODE_WIDE_PWM: pwm_o = run && (cnt16 < duty16);
      default:       pwm_o = 1'b0;
    endcase
  end

  assign lo_load_o = !run || lo_hit || wide_hit;
  assign hi_load_o = !run || hi_hit || wide_hit;
  assign cnt_lo_o  = cnt_lo_q;
  assign cnt_hi_o  = cnt_hi_q;
  assign irq_lo_o  = irq_lo_q;
  assign irq_hi_o  = irq_hi_q;
endmodule

// File: rtl/pwm_timer16.sv
`timescale 1ns/1ps
module pwm_timer16
  import t1_pkg::*;
#(
  parameter int unsigned HALF_W    = 8,
  parameter int unsigned MIN_PWM_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_x2_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o,
  output logic              irq_o
);
  t1_ctrl_t          ctrl_q;
  logic [HALF_W-1:0] per_lo_a, per_hi_a, duty_lo_a, duty_hi_a, cnt_lo, cnt_hi;
  logic              lo_load, hi_load, narrow_step, wide_step;

  t1_regfile #(.HALF_W(HALF_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lo_load_i (lo_load),
    .hi_load_i (hi_load),
    .ctrl_o    (ctrl_q),
    .per_lo_o  (per_lo_a),
    .per_hi_o  (per_hi_a),
    .duty_lo_o (duty_lo_a),
    .duty_hi_o (duty_hi_a)
  );

  t1_step_gen u_step (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (ctrl_q.run),
    .half_i        (ctrl_q.half),
    .tick_i        (tick_x2_i),
    .narrow_step_o (narrow_step),
    .wide_step_o   (wide_step)
  );

  t1_core #(.HALF_W(HALF_W), .MIN_PWM_W(MIN_PWM_W)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_i        (ctrl_q),
    .narrow_step_i (narrow_step),
    .wide_step_i   (wide_step),
    .per_lo_i      (per_lo_a),
    .per_hi_i      (per_hi_a),
    .duty_lo_i     (duty_lo_a),
    .duty_hi_i     (duty_hi_a),
    .lo_load_o     (lo_load),
    .hi_load_o     (hi_load),
    .cnt_lo_o      (cnt_lo),
    .cnt_hi_o      (cnt_hi),
    .pwm_o         (pwm_o),
    .irq_lo_o      (irq_lo_o),
    .irq_hi_o      (irq_hi_o)
  );

  assign irq_o = irq_lo_o | irq_hi_o;
endmodule

// File: rtl/t1_checker.sv
`timescale 1ns/1ps
module t1_checker #(
  parameter int unsigned HALF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_x2_i,
  input logic              run_i,
  input logic [1:0]        mode_i,
  input logic [HALF_W-1:0] cnt_lo_i,
  input logic [HALF_W-1:0] cnt_hi_i,
  input logic [HALF_W-1:0] duty_lo_i,
  input logic [HALF_W-1:0] duty_hi_i,
  input logic              pwm_o,
  input logic              irq_lo_o,
  input logic              irq_o
);
  assert_idle_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_lo_i == '0 && cnt_hi_i == '0));

  assert_idle_pwm_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_o);

  assert_irq_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_x2_i));

  assert_wide_lo_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i[1]) |-> !irq_lo_o);

  assert_zero_duty_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == 2'd3 && duty_lo_i == '0 && duty_hi_i == '0) |-> !pwm_o);
endmodule

bind pwm_timer16 t1_checker #(.HALF_W(HALF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_x2_i (tick_x2_i),
  .run_i     (ctrl_q.run),
  .mode_i    (ctrl_q.mode),
  .cnt_lo_i  (cnt_lo),
  .cnt_hi_i  (cnt_hi),
  .duty_lo_i (duty_lo_a),
  .duty_hi_i (duty_hi_a),
  .pwm_o     (pwm_o),
  .irq_lo_o  (irq_lo_o),
  .irq_o     (irq_o)
);

// File: tb/pwm_timer16_test.sv
`timescale 1ns/1ps
module pwm_timer16_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_x2_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       pwm_o, irq_lo_o, irq_hi_o, irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    rnd_tick = 1'b0;
  string seg_tag = "R1";

  pwm_timer16 uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_x2_i(tick_x2_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o), .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  // reference model, written from the requirements
  logic [7:0] m_ctrl;
  int  m_stg [4];
  int  m_act [4];
  int  m_lo, m_hi, c16, lim16, mw, md;
  bit  m_phase, m_irq_lo, m_irq_hi, mr, nst, wst, mwide, lh, hh, wh;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = '0; m_phase = 0; m_lo = 0; m_hi = 0; m_irq_lo = 0; m_irq_hi = 0;
      for (int i = 0; i < 4; i++) begin m_stg[i] = 0; m_act[i] = 0; end
    end else begin
      mr    = m_ctrl[7];
      md    = int'(m_ctrl[1:0]);
      mw    = 9 + int'(m_ctrl[5:3]);
      nst   = mr && tick_x2_i && m_phase;
      wst   = m_ctrl[2] ? (mr && tick_x2_i) : nst;
      mwide = md >= 2;
      c16   = m_hi * 256 + m_lo;
      lim16 = (md == 3) ? (1 << mw) - 1 : m_act[1] * 256 + m_act[0];
      lh    = !mwide && nst && m_lo == m_act[0];
      hh    = !mwide && nst && m_hi == ((md == 1) ? 255 : m_act[1]);
      wh    = mwide && wst && c16 == lim16;
      if (!mr) begin
        m_lo = 0; m_hi = 0;
      end else if (mwide) begin
        if (wst) begin
          c16 = wh ? 0 : c16 + 1;
          m_lo = c16 % 256; m_hi = c16 / 256;
        end
      end else if (nst) begin
        m_lo = lh ? 0 : (m_lo + 1) % 256;
        m_hi = hh ? 0 : (m_hi + 1) % 256;
      end
      m_irq_lo = lh;
      m_irq_hi = hh || wh;
      if (!mr || lh || wh) begin m_act[0] = m_stg[0]; m_act[2] = m_stg[2]; end
      if (!mr || hh || wh) begin m_act[1] = m_stg[1]; m_act[3] = m_stg[3]; end
      m_phase = !mr ? 1'b0 : (tick_x2_i ? !m_phase : m_phase);
      if (wr_en_i) begin
        if (wr_addr_i == 3'd4) m_ctrl = wr_data_i;
        else if (wr_addr_i < 3'd4) m_stg[wr_addr_i] = int'(wr_data_i);
      end
    end
  end

  function automatic bit exp_pwm();
    if (!m_ctrl[7]) return 1'b0;
    if (m_ctrl[1:0] == 2'd1) return m_hi < m_act[3];
    if (m_ctrl[1:0] == 2'd3) return (m_hi * 256 + m_lo) < (m_act[3] * 256 + m_act[2]);
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(seg_tag, "pwm_o", int'(pwm_o), int'(exp_pwm()));
    chk(seg_tag, "irq_lo_o", int'(irq_lo_o), int'(m_irq_lo));
    chk(seg_tag, "irq_hi_o", int'(irq_hi_o), int'(m_irq_hi));
    chk("R10", "irq_o", int'(irq_o), int'(m_irq_lo || m_irq_hi));
  endtask

  task automatic step_clk();
    @(negedge clk_i);
    compare();
    wr_en_i   = 1'b0;
    tick_x2_i = rnd_tick ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic wr(int a, int d);
    step_clk();
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 8'(d);
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step_clk();
  endtask

  // ctrl: [1:0] mode, [2] half rate, [5:3] width select, [7] run
  task automatic start(string tag, int pl, int ph, int dl, int dh, int ctl, bit rt, int n);
    wr(4, ctl & 8'h7F);
    wr(0, pl); wr(1, ph); wr(2, dl); wr(3, dh);
    step_clk();
    seg_tag = tag; rnd_tick = rt;
    wr(4, ctl | 8'h80);
    run_n(n);
  endtask

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    seg_tag = "R1";
    for (int i = 0; i < 3; i++) step_clk();
    chk("R1", "pwm_o in reset", int'(pwm_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    run_n(4);

    start("R2", 3, 6, 0, 0, 8'h00, 0, 120);
    start("R3", 5, 2, 0, 0, 8'h00, 1, 400);
    start("R3", 41, 0, 0, 0, 8'h02, 1, 500);
    start("R4", 9, 0, 0, 100, 8'h01, 0, 1100);
    // R9: mid-period writes on the high and low halves
    seg_tag = "R9";
    wr(3, 30); wr(0, 2); run_n(1200);
    start("R8", 4, 0, 0, 0, 8'h01, 0, 600);
    start("R8", 1, 0, 0, 255, 8'h01, 0, 1100);
    start("R8", 0, 0, 0, 0, 8'h03, 0, 2100);
    start("R8", 0, 0, 8'h58, 8'h02, 8'h07, 0, 1100);
    start("R5", 8'h2C, 8'h01, 0, 0, 8'h02, 0, 1300);
    start("R7", 8'hFF, 8'h01, 0, 0, 8'h06, 0, 1100);
    start("R7", 0, 0, 8'hBC, 8'h02, 8'h16, 0, 4200);
    start("R6", 0, 0, 8'h2D, 8'h01, 8'h0B, 1, 4300);
    // R9: wide PWM duty changed mid-period
    seg_tag = "R9";
    wr(2, 8'h10); wr(3, 8'h03); run_n(2200);
    start("R6", 0, 0, 8'h00, 8'h80, 8'h3F, 0, 66000);
    // R11: stopped, writes and ticks must not disturb outputs
    wr(4, 8'h01);
    seg_tag = "R11"; rnd_tick = 1;
    wr(3, 200); wr(0, 0); run_n(200);
    // random segments
    for (int k = 0; k < 6; k++) begin
      int m  = $urandom % 4;
      int cw = m | (($urandom % 2) << 2) | (($urandom % 3) << 3);
      string t = (m == 0) ? "R2" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
      start(t, $urandom % 64, $urandom % 4, $urandom % 256, $urandom % 4, cw, 1'($urandom % 2), 2000);
    end
    wr(4, 0);
    run_n(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule